// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines the fetch address with a short shift register that holds the outcomes of the most recent resolved branches. The history value picks one of several banks of 2-bit prediction states, and word-aligned address bits pick the entry inside that bank. A prediction is returned combinationally in the cycle the address is presented, together with the history value in use. The front end carries that history value along with the branch.

When the branch resolves, the back end presents the branch address, the real outcome and the carried history snapshot. The entry addressed by the snapshot, not by the live register, is then trained. The live history register shifts the outcome in. Each entry holds a direction bit and a "previous guess was wrong" bit, so the direction only reverses when two wrong guesses in a row have been seen.

Top module: `gp_dir_pred`

## Requirements
- R1: `fetch_taken` is bit 1 of the entry at address {`fetch_hist`, `fetch_pc`[IDX_W+1:2]}, valid in the same cycle as `fetch_pc`. The address bits [1:0] have no effect on the prediction.
- R2: `fetch_hist` shows the live history register, with the most recent outcome in bit 0.
- R3: On a clock edge with `upd_valid` high, the history register shifts left and takes `upd_taken` into bit 0, where taken = 1. Without `upd_valid` the register holds its value.
- R4: An update writes the entry at {`upd_hist`, `upd_pc`[IDX_W+1:2]}. The entry chosen by the live history is left alone unless it is the same entry.
- R5: Each entry is encoded as {direction, armed}, where direction 1 means taken. A correct outcome keeps the direction and clears armed.
- R6: A wrong outcome on an entry with armed = 0 keeps the direction and sets armed.
- R7: A wrong outcome on an entry with armed = 1 reverses the direction and clears armed.
- R8: After reset the history is 0 and every entry is 2'b01 (not taken, armed). A single taken update on a fresh entry therefore turns its prediction to taken.
- R9: When a prediction read and an update address the same entry in the same cycle, the read returns the value from before the update.
- R10: Entries with the same address bits but different history banks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_taken | output | 1 | Predicted direction, 1 = taken |
| fetch_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History snapshot carried from prediction time |

## Verification
A corrupted armed bit stays hidden at the ports until the next wrong outcome on that entry. It then shows up one cycle later as a direction that reverses too early or too late. The bench therefore drives wrong outcomes in pairs and single wrong outcomes, and reads back after each one. A wrong history shift or a wrong snapshot choice sends training to the wrong bank. This appears on `fetch_hist` right after the update edge, and on `fetch_taken` as soon as the history is steered back to the trained bank.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef logic [1:0] ctr_t;

  // {direction, armed}
  localparam ctr_t CTR_NT_FIRM = 2'b00;
  localparam ctr_t CTR_NT_SOFT = 2'b01;
  localparam ctr_t CTR_TK_FIRM = 2'b10;
  localparam ctr_t CTR_TK_SOFT = 2'b11;

  function automatic logic f_dir(input ctr_t s);
    return s[1];
  endfunction

  function automatic logic f_armed(input ctr_t s);
    return s[0];
  endfunction

  // Direction reverses only when a miss arrives while already armed.
  function automatic ctr_t f_train(input ctr_t s, input logic taken);
    ctr_t n;
    if (f_dir(s) == taken)   n = {f_dir(s), 1'b0};
    else if (!f_armed(s))    n = {f_dir(s), 1'b1};
    else                     n = {taken, 1'b0};
    return n;
  endfunction

endpackage

// File: rtl/gp_hist_reg.sv
module gp_hist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_next;

  assign hist_next = {hist_q[HIST_W-2:0], shift_bit};

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_next;
  end

  assign hist_o = hist_q;

  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(shift_bit)) &&
                 (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gp_index.sv
module gp_index #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2,
  localparam int ADDR_W = IDX_W + HIST_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [ADDR_W-1:0] addr
);

  // History picks the bank, word-aligned address bits pick the row.
  function automatic logic [ADDR_W-1:0] f_addr(input logic [PC_W-1:0] p,
                                               input logic [HIST_W-1:0] h);
    return {h, p[IDX_W+1:2]};
  endfunction

  assign addr = f_addr(pc, hist);

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[1:0], pc[PC_W-1:IDX_W+2]};

endmodule

// File: rtl/gp_pht.sv
module gp_pht
  import gp_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ENTRIES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output ctr_t              rd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_taken
);

  ctr_t tbl_q [ENTRIES];

  ctr_t wr_old;
  ctr_t wr_new;
  logic wr_miss;

  assign rd_state = tbl_q[rd_addr];
  assign wr_old   = tbl_q[wr_addr];
  assign wr_new   = f_train(wr_old, wr_taken);
  assign wr_miss  = f_dir(wr_old) != wr_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_NT_SOFT;
    end else if (wr_en) begin
      tbl_q[wr_addr] <= wr_new;
    end
  end

  p_hit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_miss) |=> tbl_q[$past(wr_addr)] == {$past(wr_old[1]), 1'b0});

  p_first_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_miss && !wr_old[0]) |=>
      tbl_q[$past(wr_addr)] == {$past(wr_old[1]), 1'b1});

  p_second_miss_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_miss && wr_old[0]) |=>
      tbl_q[$past(wr_addr)] == {~$past(wr_old[1]), 1'b0});

endmodule

// File: rtl/gp_dir_pred.sv
module gp_dir_pred
  import gp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2,
  localparam int ADDR_W = IDX_W + HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_taken,
  output logic [HIST_W-1:0] fetch_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  logic [HIST_W-1:0] live_hist;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  ctr_t              rd_state;

  gp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken),
    .hist_o(live_hist)
  );

  gp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_rd_idx (
    .pc(fetch_pc), .hist(live_hist), .addr(rd_addr)
  );

  gp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_wr_idx (
    .pc(upd_pc), .hist(upd_hist), .addr(wr_addr)
  );

  gp_pht #(.ADDR_W(ADDR_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_state(rd_state),
    .wr_en(upd_valid), .wr_addr(wr_addr), .wr_taken(upd_taken)
  );

  assign fetch_taken = f_dir(rd_state);
  assign fetch_hist  = live_hist;

endmodule

// File: tb/sim_gp_dir_pred.sv
module sim_gp_dir_pred;
  localparam int IDX_W = 10;
  localparam int ENT   = 1 << (IDX_W + 2);
  localparam logic [31:0] SCR = 32'h0000_0FFC;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        fetch_taken;
  logic [1:0]  fetch_hist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [1:0]  upd_hist;

  gp_dir_pred u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_pc(fetch_pc), .fetch_taken(fetch_taken), .fetch_hist(fetch_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist(upd_hist)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [1:0] m_tbl [ENT];
  logic [1:0] m_hist;

  // {pc, snapshot, taken}
  localparam logic [34:0] VEC [16] = '{
    {32'h0000_0040, 2'd0, 1'b1}, {32'h0000_0040, 2'd1, 1'b1},
    {32'h0000_0044, 2'd3, 1'b0}, {32'h0000_0040, 2'd3, 1'b0},
    {32'h0000_1040, 2'd0, 1'b0}, {32'h0000_0040, 2'd0, 1'b0},
    {32'h0000_0048, 2'd2, 1'b1}, {32'h0000_0048, 2'd2, 1'b0},
    {32'h0000_0048, 2'd2, 1'b1}, {32'h0000_0044, 2'd1, 1'b1},
    {32'h0000_0044, 2'd1, 1'b1}, {32'h0000_1040, 2'd3, 1'b1},
    {32'h0000_0040, 2'd3, 1'b1}, {32'h0000_0048, 2'd1, 1'b0},
    {32'h0000_0048, 2'd1, 1'b0}, {32'h0000_0044, 2'd2, 1'b0}
  };

  function automatic logic [1:0] m_next(input logic [1:0] s, input logic t);
    case (s)
      2'b00:   m_next = t ? 2'b01 : 2'b00;
      2'b01:   m_next = t ? 2'b10 : 2'b00;
      2'b10:   m_next = t ? 2'b10 : 2'b11;
      default: m_next = t ? 2'b10 : 2'b00;
    endcase
  endfunction

  function automatic logic m_pred(input logic [31:0] pc);
    logic [1:0] s;
    s = m_tbl[{m_hist, pc[11:2]}];
    return s[1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    upd_hist = '0; fetch_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < ENT; i++) m_tbl[i] = 2'b01;
    m_hist = 2'b00;
  endtask

  task automatic do_upd(input logic [31:0] pc, input logic [1:0] snap, input logic t);
    logic [11:0] a;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_hist = snap; upd_taken = t;
    a = {snap, pc[11:2]};
    m_tbl[a] = m_next(m_tbl[a], t);
    m_hist = {m_hist[0], t};
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic set_hist(input logic [1:0] h);
    do_upd(SCR, 2'd0, h[1]);
    do_upd(SCR, 2'd0, h[0]);
  endtask

  task automatic probe(input logic [31:0] pc);
    fetch_pc = pc;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] h_keep;
    do_reset();

    // R8: reset state
    probe(32'h0);
    chk("R8 hist after reset", 32'(fetch_hist), 32'd0);
    probe(32'h40);   chk("R8 pred after reset", 32'(fetch_taken), 32'd0);
    probe(32'hFFC);  chk("R8 pred after reset", 32'(fetch_taken), 32'd0);

    // Vector walk, checked against the bench model (R1, R2, R3, R5, R6, R7)
    for (int v = 0; v < 16; v++) begin
      do_upd(VEC[v][34:3], VEC[v][2:1], VEC[v][0]);
      probe(VEC[v][34:3]);
      chk("R3 hist shift", 32'(fetch_hist), 32'(m_hist));
      chk("R1 prediction", 32'(fetch_taken), 32'(m_pred(VEC[v][34:3])));
      probe(VEC[v][34:3] | 32'h3);
      chk("R1 low bits ignored", 32'(fetch_taken), 32'(m_pred(VEC[v][34:3])));
    end

    // R3: no update, history holds
    h_keep = fetch_hist;
    repeat (5) @(negedge clk);
    probe(32'h0);
    chk("R3 hold when idle", 32'(fetch_hist), 32'(h_keep));

    // Directed training sequence on one entry, bank 0
    do_reset();
    do_upd(32'h100, 2'd0, 1'b1); set_hist(2'd0); probe(32'h100);
    chk("R8 first taken flips soft NT", 32'(fetch_taken), 32'd1);
    do_upd(32'h100, 2'd0, 1'b0); set_hist(2'd0); probe(32'h100);
    chk("R6 single miss keeps taken", 32'(fetch_taken), 32'd1);
    do_upd(32'h100, 2'd0, 1'b1); set_hist(2'd0); probe(32'h100);
    chk("R5 hit keeps taken", 32'(fetch_taken), 32'd1);
    do_upd(32'h100, 2'd0, 1'b0); set_hist(2'd0); probe(32'h100);
    chk("R6 miss after hit keeps taken", 32'(fetch_taken), 32'd1);
    do_upd(32'h100, 2'd0, 1'b0); set_hist(2'd0); probe(32'h100);
    chk("R7 second miss flips", 32'(fetch_taken), 32'd0);
    do_upd(32'h100, 2'd0, 1'b1); set_hist(2'd0); probe(32'h100);
    chk("R6 single miss keeps not-taken", 32'(fetch_taken), 32'd0);
    do_upd(32'h100, 2'd0, 1'b1); set_hist(2'd0); probe(32'h100);
    chk("R7 second miss flips back", 32'(fetch_taken), 32'd1);

    // R4 / R10: snapshot bank trained, live bank untouched
    set_hist(2'd3);
    do_upd(32'h200, 2'd0, 1'b1);
    set_hist(2'd3); probe(32'h200);
    chk("R4 live bank untouched", 32'(fetch_taken), 32'd0);
    set_hist(2'd0); probe(32'h200);
    chk("R4 snapshot bank trained", 32'(fetch_taken), 32'd1);
    set_hist(2'd1); probe(32'h200);
    chk("R10 other bank independent", 32'(fetch_taken), 32'd0);
    chk("R2 hist shown", 32'(fetch_hist), 32'd1);

    // R9: same-entry read during write returns old value
    set_hist(2'd2);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h300; upd_hist = 2'd2; upd_taken = 1'b1;
    fetch_pc = 32'h300;
    m_tbl[{2'd2, 10'h0C0}] = m_next(m_tbl[{2'd2, 10'h0C0}], 1'b1);
    m_hist = {m_hist[0], 1'b1};
    #1;
    chk("R9 read returns old", 32'(fetch_taken), 32'd0);
    @(negedge clk);
    upd_valid = 1'b0;
    set_hist(2'd2); probe(32'h300);
    chk("R9 write landed", 32'(fetch_taken), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule